// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block turns interrupt events into fixed-size records in a circular buffer in memory. Each accepted event becomes a 16-byte vector of four 32-bit words. The vector is written to memory one word at a time through a word-write port. The block keeps a byte-granular write pointer. A software agent reads vectors out of the ring and reports its progress through a read-pointer register. While the two pointers differ, the ring holds unread vectors and the interrupt output can be raised.

A small register file sets up the ring:

- the ring base, which is 256-byte aligned;
- the ring length, given as log2 of its size in words;
- the read and write pointers;
- a writeback address;
- a control word with enable bits.

If the writer laps the reader, the block keeps writing over the oldest data. It records the event in a sticky flag in bit 0 of the write-pointer word, and software clears the flag through a control bit. When writeback is on, each pointer update is followed by one more memory write that mirrors the write-pointer word, so software can poll memory instead of the register.

Both streaming edges use valid/ready.

- **Event input.** An event transfers on a cycle where `ev_valid` and `ev_ready` are both high. The producer must hold `ev_valid` and the fields until that cycle.
- **Memory port.** A word transfers on a cycle where `mw_valid` and `mw_ready` are both high. While `mw_ready` is low, the block holds `mw_addr` and `mw_data` unchanged, so the memory side may stall for any number of cycles.

Top module: `ivring_writer`

## Requirements
- R1: `ev_ready` is high only while the ring-enable control bit is set and no vector or writeback is in flight. An event is taken on a cycle where `ev_valid` and `ev_ready` are both high.
- R2: Vector words are laid out as follows:
  - word 0 is `{24'b0, src_id}`;
  - word 1 is `{4'b0, src_data[27:0]}`;
  - word 2 is `{pasid[15:0], vmid[7:0], ring_id[7:0]}`;
  - word 3 is zero.
- R3: The four words go out in order 0, 1, 2, 3. Word k goes to byte address `{base[31:0], 8'h00} + wptr + 4*k`. Address and data stay stable while `mw_ready` is low.
- R4: The write pointer is a byte count. It advances by 16 only on the cycle after word 3 is accepted, and it wraps with mask `(4 << L) - 1`. L is the size field clamped to the range 2 to 16.
- R5: When overflow detection is enabled, a vector whose advanced pointer equals the read pointer sets bit 0 of the write-pointer word. The bit stays set until a control write with the overflow-clear bit set, or a software write of the write pointer.
- R6: When writeback is enabled, a pointer update is followed by one more write. It carries the write-pointer word (pointer with the overflow flag in bit 0) to address `{wb_hi[7:0], wb_lo[31:0]}`.
- R7: `irq_out` is high when interrupts are enabled and the masked pointers differ. When re-arm is enabled, `irq_out` is low for exactly the one cycle after a read-pointer write. This gives a fresh rising edge if entries remain.
- R8: Clearing ring-enable blocks new events but lets an in-flight vector finish. A write to the write-pointer register takes effect only while the ring is disabled.
- R9: `busy` is high from the cycle after an event is accepted until the last word, or the writeback, is accepted.
- R10: After reset, the following are low or zero: all control bits, both pointers, the overflow flag, `irq_out`, `busy`, `ev_ready` and `mw_valid`.
- R11: Register offsets on `cfg_addr` are:

  | Offset | Register |
  |---|---|
  | 0 | control |
  | 1 | base |
  | 2 | size |
  | 3 | read pointer |
  | 4 | write pointer |
  | 5 | writeback low |
  | 6 | writeback high |

  The control bits are:

  | Bit | Function |
  |---|---|
  | 0 | ring enable |
  | 1 | interrupt enable |
  | 2 | overflow detect |
  | 3 | writeback enable |
  | 4 | re-arm |
  | 5 | overflow clear, write-only pulse |

  `cfg_rdata` returns the register selected by `cfg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| ev_valid | input | 1 | Event valid |
| ev_ready | output | 1 | Event ready |
| ev_src_id | input | 8 | Source identifier |
| ev_src_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring identifier |
| ev_vmid | input | 8 | Virtual machine identifier |
| ev_pasid | input | 16 | Process address-space identifier |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write ready |
| mw_addr | output | 40 | Memory byte address |
| mw_data | output | 32 | Memory write data |
| irq_out | output | 1 | Interrupt output |
| busy | output | 1 | Vector or writeback in progress |

## Verification
The stability check on the memory port assumes that software does not rewrite the base, size or write pointer while a vector is in flight. Those values feed the address, so rewriting them would move it. The bench issues such writes only once `busy` has fallen.

The sticky-flag check assumes that an overflow-clear write never lands in the same cycle as the final word of a vector. Likewise, the address model assumes that configuration writes do not coincide with event acceptance. The stimulus meets both assumptions by waiting for idle before each register access. The one exception is a deliberate disable during a stalled vector, which only touches the control bits.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  localparam int unsigned VEC_BYTES = 16;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_BASE  = 3'd1;
  localparam logic [2:0] REG_SIZE  = 3'd2;
  localparam logic [2:0] REG_RPTR  = 3'd3;
  localparam logic [2:0] REG_WPTR  = 3'd4;
  localparam logic [2:0] REG_WBLO  = 3'd5;
  localparam logic [2:0] REG_WBHI  = 3'd6;

  localparam int unsigned CB_RING  = 0;
  localparam int unsigned CB_INTR  = 1;
  localparam int unsigned CB_OVFEN = 2;
  localparam int unsigned CB_WB    = 3;
  localparam int unsigned CB_REARM = 4;
  localparam int unsigned CB_OCLR  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_W0, ST_W1, ST_W2, ST_W3, ST_WB
  } wr_state_e;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring_id;
    logic [27:0] src_data;
    logic [7:0]  src_id;
  } iv_event_t;

endpackage

// File: rtl/ivr_regfile.sv
module ivr_regfile import ivr_pkg::*; #(
  parameter int unsigned PTR_W    = 18,
  parameter int unsigned MAX_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             wp_upd,
  output logic             ring_en,
  output logic             intr_en,
  output logic             ovf_en,
  output logic             wb_en,
  output logic             rearm_en,
  output logic [31:0]      base_hi,
  output logic [PTR_W-1:0] wptr_m,
  output logic [PTR_W-1:0] rptr_m,
  output logic [31:0]      wptr_word,
  output logic [39:0]      wb_addr,
  output logic             rptr_wr,
  output logic [31:0]      cfg_rdata
);

  localparam logic [4:0] MIN_L = 5'd2;
  localparam logic [4:0] MAX_L = 5'(MAX_LOG2);
  localparam int unsigned PAD  = 32 - PTR_W;

  logic [4:0]       ctrl_q;
  logic [31:0]      base_q;
  logic [4:0]       size_q;
  logic [PTR_W-1:0] rptr_q;
  logic [PTR_W-1:0] wptr_q;
  logic             ovf_q;
  logic [31:0]      wb_lo_q;
  logic [7:0]       wb_hi_q;

  logic [4:0]       size_eff;
  logic [PTR_W-1:0] ptr_mask;
  logic [PTR_W-1:0] wptr_next;
  logic             overrun;
  logic             wr_ctrl, wr_wptr, sw_wptr_ok, ovf_clr;

  always_comb begin
    if (size_q < MIN_L)      size_eff = MIN_L;
    else if (size_q > MAX_L) size_eff = MAX_L;
    else                     size_eff = size_q;
  end

  assign ptr_mask  = (PTR_W'(4) << size_eff) - PTR_W'(1);
  assign wptr_m    = wptr_q & ptr_mask;
  assign rptr_m    = rptr_q & ptr_mask;
  assign wptr_next = (wptr_m + PTR_W'(VEC_BYTES)) & ptr_mask;
  assign overrun   = ovf_en && (wptr_next == rptr_m);

  assign ring_en  = ctrl_q[CB_RING];
  assign intr_en  = ctrl_q[CB_INTR];
  assign ovf_en   = ctrl_q[CB_OVFEN];
  assign wb_en    = ctrl_q[CB_WB];
  assign rearm_en = ctrl_q[CB_REARM];
  assign base_hi  = base_q;
  assign wb_addr  = {wb_hi_q, wb_lo_q};

  assign wr_ctrl    = cfg_we && (cfg_addr == REG_CTRL);
  assign wr_wptr    = cfg_we && (cfg_addr == REG_WPTR);
  assign rptr_wr    = cfg_we && (cfg_addr == REG_RPTR);
  assign sw_wptr_ok = wr_wptr && !ring_en;
  assign ovf_clr    = (wr_ctrl && cfg_wdata[CB_OCLR]) || sw_wptr_ok;

  assign wptr_word = {{PAD{1'b0}}, wptr_m[PTR_W-1:1], ovf_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      base_q  <= '0;
      size_q  <= '0;
      rptr_q  <= '0;
      wptr_q  <= '0;
      ovf_q   <= 1'b0;
      wb_lo_q <= '0;
      wb_hi_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= cfg_wdata[4:0];
      if (cfg_we && cfg_addr == REG_BASE) base_q <= cfg_wdata;
      if (cfg_we && cfg_addr == REG_SIZE) size_q <= cfg_wdata[4:0];
      if (rptr_wr) rptr_q <= {cfg_wdata[PTR_W-1:4], 4'b0};
      if (cfg_we && cfg_addr == REG_WBLO) wb_lo_q <= cfg_wdata;
      if (cfg_we && cfg_addr == REG_WBHI) wb_hi_q <= cfg_wdata[7:0];
      if (wp_upd)          wptr_q <= wptr_next;
      else if (sw_wptr_ok) wptr_q <= {cfg_wdata[PTR_W-1:4], 4'b0};
      if (wp_upd && overrun) ovf_q <= 1'b1;
      else if (ovf_clr)      ovf_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      REG_CTRL: cfg_rdata = {27'b0, ctrl_q};
      REG_BASE: cfg_rdata = base_q;
      REG_SIZE: cfg_rdata = {27'b0, size_q};
      REG_RPTR: cfg_rdata = {{PAD{1'b0}}, rptr_q};
      REG_WPTR: cfg_rdata = wptr_word;
      REG_WBLO: cfg_rdata = wb_lo_q;
      REG_WBHI: cfg_rdata = {24'b0, wb_hi_q};
      default:  cfg_rdata = '0;
    endcase
  end

  // R5: the flag holds until an explicit clear
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R8: with the ring enabled, a software pointer write leaves the pointer alone
  p_wptr_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wptr && ring_en && !wp_upd) |=> $stable(wptr_q));

endmodule

// File: rtl/ivr_vector_fsm.sv
module ivr_vector_fsm import ivr_pkg::*; #(
  parameter int unsigned PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  iv_event_t        ev_vec,
  output logic             ev_ready,
  input  logic             ring_en,
  input  logic             wb_en,
  input  logic [31:0]      base_hi,
  input  logic [PTR_W-1:0] wptr_m,
  input  logic [31:0]      wptr_word,
  input  logic [39:0]      wb_addr,
  input  logic             mw_ready,
  output logic             mw_valid,
  output logic [39:0]      mw_addr,
  output logic [31:0]      mw_data,
  output logic             wp_upd,
  output logic             busy
);

  wr_state_e state_q, state_d;
  iv_event_t vec_q;
  logic [1:0] idx;

  assign busy     = (state_q != ST_IDLE);
  assign ev_ready = ring_en && !busy;
  assign mw_valid = busy;
  assign wp_upd   = (state_q == ST_W3) && mw_ready;

  always_comb begin
    unique case (state_q)
      ST_W1:   idx = 2'd1;
      ST_W2:   idx = 2'd2;
      ST_W3:   idx = 2'd3;
      default: idx = 2'd0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_W0:   mw_data = {24'b0, vec_q.src_id};
      ST_W1:   mw_data = {4'b0, vec_q.src_data};
      ST_W2:   mw_data = {vec_q.pasid, vec_q.vmid, vec_q.ring_id};
      ST_WB:   mw_data = wptr_word;
      default: mw_data = '0;
    endcase
  end

  assign mw_addr = (state_q == ST_WB) ? wb_addr
                 : ({base_hi, 8'h00} + 40'(wptr_m) + 40'({idx, 2'b00}));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ev_valid && ev_ready) state_d = ST_W0;
      ST_W0:   if (mw_ready) state_d = ST_W1;
      ST_W1:   if (mw_ready) state_d = ST_W2;
      ST_W2:   if (mw_ready) state_d = ST_W3;
      ST_W3:   if (mw_ready) state_d = wb_en ? ST_WB : ST_IDLE;
      ST_WB:   if (mw_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ev_valid && ev_ready) vec_q <= ev_vec;
    end
  end

  // R3: a stalled word keeps its address and data
  p_mw_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  // R9: an accepted event makes the block busy on the next cycle
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> busy);

  // R1: no event is taken while a transfer is outstanding
  p_no_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !ev_ready);

endmodule

// File: rtl/ivr_irq_gen.sv
module ivr_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic intr_en,
  input  logic rearm_en,
  input  logic rptr_wr,
  input  logic pending,
  output logic irq_out
);

  logic gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= rptr_wr && rearm_en;
  end

  assign irq_out = intr_en && pending && !gap_q;

  // R7: interrupts disabled means a quiet output
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_en |-> !irq_out);

  // R7: re-arm drops the line for the cycle after a read-pointer write
  p_irq_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_wr && rearm_en) |=> !irq_out);

endmodule

// File: rtl/ivring_writer.sv
module ivring_writer import ivr_pkg::*; #(
  parameter int unsigned PTR_W    = 18,
  parameter int unsigned MAX_LOG2 = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [7:0]  ev_src_id,
  input  logic [27:0] ev_src_data,
  input  logic [7:0]  ev_ring_id,
  input  logic [7:0]  ev_vmid,
  input  logic [15:0] ev_pasid,
  output logic        mw_valid,
  input  logic        mw_ready,
  output logic [39:0] mw_addr,
  output logic [31:0] mw_data,
  output logic        irq_out,
  output logic        busy
);

  logic             ring_en, intr_en, ovf_en, wb_en, rearm_en;
  logic [31:0]      base_hi, wptr_word;
  logic [PTR_W-1:0] wptr_m, rptr_m;
  logic [39:0]      wb_addr;
  logic             rptr_wr, wp_upd;
  iv_event_t        ev_vec;

  assign ev_vec = '{pasid: ev_pasid, vmid: ev_vmid, ring_id: ev_ring_id,
                    src_data: ev_src_data, src_id: ev_src_id};

  ivr_regfile #(.PTR_W(PTR_W), .MAX_LOG2(MAX_LOG2)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wp_upd(wp_upd), .ring_en(ring_en),
    .intr_en(intr_en), .ovf_en(ovf_en), .wb_en(wb_en), .rearm_en(rearm_en),
    .base_hi(base_hi), .wptr_m(wptr_m), .rptr_m(rptr_m),
    .wptr_word(wptr_word), .wb_addr(wb_addr), .rptr_wr(rptr_wr),
    .cfg_rdata(cfg_rdata)
  );

  ivr_vector_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_vec(ev_vec),
    .ev_ready(ev_ready), .ring_en(ring_en), .wb_en(wb_en),
    .base_hi(base_hi), .wptr_m(wptr_m), .wptr_word(wptr_word),
    .wb_addr(wb_addr), .mw_ready(mw_ready), .mw_valid(mw_valid),
    .mw_addr(mw_addr), .mw_data(mw_data), .wp_upd(wp_upd), .busy(busy)
  );

  ivr_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .intr_en(intr_en), .rearm_en(rearm_en),
    .rptr_wr(rptr_wr), .pending(wptr_m != rptr_m), .irq_out(irq_out)
  );

  // R4: the pointer moves only after a final-word handshake or a register write
  p_wptr_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_m != $past(wptr_m)) |-> $past(wp_upd || cfg_we));

  // R1: ring disabled keeps the event input closed
  p_disabled_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en |-> !ev_ready);

endmodule

// File: tb/tb_ivring_writer.sv
`timescale 1ns/1ps
module tb_ivring_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_src_id = '0;
  logic [27:0] ev_src_data = '0;
  logic [7:0]  ev_ring_id = '0;
  logic [7:0]  ev_vmid = '0;
  logic [15:0] ev_pasid = '0;
  logic        mw_valid;
  logic        mw_ready = 1'b1;
  logic [39:0] mw_addr;
  logic [31:0] mw_data;
  logic        irq_out;
  logic        busy;

  always #2.5 clk = ~clk;

  ivring_writer dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_src_id(ev_src_id), .ev_src_data(ev_src_data),
    .ev_ring_id(ev_ring_id), .ev_vmid(ev_vmid), .ev_pasid(ev_pasid),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .irq_out(irq_out), .busy(busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int bp_level = 0;

  // reference state
  int      m_ctrl, m_size, m_rptr, m_wptr, m_ovf, m_wb_hi, m_gap;
  longint  m_base, m_wb_lo;
  longint  q_addr[$];
  longint  q_data[$];
  int      q_kind[$];

  function automatic int fmask(int s);
    int e;
    e = (s < 2) ? 2 : ((s > 16) ? 16 : s);
    return ((4 << e) - 1) & 32'h3FFFF;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // back-pressure driver
  always @(posedge clk) begin
    #1;
    if (bp_level == 0) mw_ready = 1'b1;
    else if (bp_level == 1) mw_ready = ($urandom_range(0, 3) != 0);
    else mw_ready = ($urandom_range(0, 3) == 0);
  end

  // per-clock reference comparison
  always @(negedge clk) begin
    int k, msk, nxt, new_gap;
    longint a, d;
    logic pend;
    if (!rst_n) begin
      m_ctrl = 0; m_size = 0; m_rptr = 0; m_wptr = 0; m_ovf = 0;
      m_wb_hi = 0; m_gap = 0; m_base = 0; m_wb_lo = 0;
      chk("R10 irq_out in reset", irq_out, 0);
      chk("R10 busy in reset", busy, 0);
      chk("R10 ev_ready in reset", ev_ready, 0);
      chk("R10 mw_valid in reset", mw_valid, 0);
    end else begin
      msk  = fmask(m_size);
      pend = ((m_wptr & msk) != (m_rptr & msk));
      chk("R7 irq_out", irq_out, 64'(((m_ctrl >> 1) & 1) != 0 && pend && m_gap == 0));
      chk("R9 busy", busy, 64'(q_kind.size() != 0));
      chk("R1 ev_ready", ev_ready, 64'((m_ctrl & 1) != 0 && q_kind.size() == 0));
      if (mw_valid && mw_ready) begin
        if (q_kind.size() == 0) begin
          chk("R8 unexpected memory write", mw_addr, 64'hFFFF_FFFF_FFFF);
        end else begin
          k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
          chk((k == 4) ? "R6 writeback addr" : "R3 word addr", mw_addr, a);
          chk((k == 4) ? "R6 writeback data" : "R2 word data", mw_data, d);
          if (k == 3) begin
            nxt = ((m_wptr & msk) + 16) & msk;
            if (((m_ctrl >> 2) & 1) != 0 && nxt == (m_rptr & msk)) m_ovf = 1;
            m_wptr = nxt;
            if (((m_ctrl >> 3) & 1) != 0) begin
              q_kind.push_back(4);
              q_addr.push_back((longint'(m_wb_hi) << 32) | m_wb_lo);
              q_data.push_back(longint'(m_wptr | m_ovf));
            end
          end
        end
      end
      new_gap = 0;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin
            m_ctrl = cfg_wdata & 31;
            if (cfg_wdata[5]) m_ovf = 0;
          end
          3'd1: m_base = longint'(cfg_wdata);
          3'd2: m_size = cfg_wdata & 31;
          3'd3: begin
            m_rptr = cfg_wdata & 32'h3FFF0;
            new_gap = (m_ctrl >> 4) & 1;
          end
          3'd4: if ((m_ctrl & 1) == 0) begin
            m_wptr = cfg_wdata & 32'h3FFF0;
            m_ovf = 0;
          end
          3'd5: m_wb_lo = longint'(cfg_wdata);
          3'd6: m_wb_hi = cfg_wdata & 255;
          default: ;
        endcase
      end
      if (ev_valid && ev_ready) begin
        msk = fmask(m_size);
        for (int i = 0; i < 4; i++) begin
          q_kind.push_back(i);
          q_addr.push_back((m_base << 8) + longint'(m_wptr & msk) + longint'(4 * i));
        end
        q_data.push_back(longint'(ev_src_id));
        q_data.push_back(longint'(ev_src_data));
        q_data.push_back(longint'({ev_pasid, ev_vmid, ev_ring_id}));
        q_data.push_back(0);
      end
      m_gap = new_gap;
    end
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    cfg_addr = a;
    @(negedge clk);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic send(input logic [7:0] s, input logic [27:0] dt, input logic [7:0] rg,
                      input logic [7:0] vm, input logic [15:0] pa);
    @(posedge clk); #1;
    ev_valid = 1'b1; ev_src_id = s; ev_src_data = dt;
    ev_ring_id = rg; ev_vmid = vm; ev_pasid = pa;
    do @(negedge clk); while (!ev_ready);
    @(posedge clk); #1;
    ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: registers read zero after reset
    rd(3'd4, 32'h0, "R10 wptr after reset");
    rd(3'd3, 32'h0, "R10 rptr after reset");
    rd(3'd0, 32'h0, "R10 ctrl after reset");

    // R11: program the ring, 16 words = 64 bytes
    cfg_wr(3'd1, 32'h0001_2345);
    cfg_wr(3'd2, 32'd4);
    cfg_wr(3'd5, 32'h0000_1000);
    cfg_wr(3'd6, 32'h0000_01AB);
    rd(3'd6, 32'h0000_00AB, "R6 writeback high keeps 8 bits");
    cfg_wr(3'd0, 32'h07);

    // R2 R3 R4: two vectors, no back-pressure
    send(8'h11, 28'hABCDEF1, 8'h01, 8'h02, 16'h0303);
    wait_idle();
    send(8'hFE, 28'hFFFFFFF, 8'hA5, 8'h5A, 16'hBEEF);
    wait_idle();
    rd(3'd4, 32'd32, "R4 wptr after two vectors");

    // R7: re-arm gap after a read-pointer write
    cfg_wr(3'd0, 32'h17);
    cfg_wr(3'd3, 32'd16);
    @(negedge clk); chk("R7 rearm gap low", irq_out, 0);
    @(negedge clk); chk("R7 rearm re-raised", irq_out, 1);
    cfg_wr(3'd3, 32'd32);
    @(negedge clk); @(negedge clk); chk("R7 no pending no irq", irq_out, 0);

    // R6 R4 R5: writeback on, back-pressure, wrap and overflow
    cfg_wr(3'd0, 32'h0F);
    bp_level = 1;
    send(8'h21, 28'h1, 8'h1, 8'h1, 16'h1); wait_idle();
    send(8'h22, 28'h2, 8'h2, 8'h2, 16'h2); wait_idle();
    send(8'h23, 28'h3, 8'h3, 8'h3, 16'h3); wait_idle();
    rd(3'd4, 32'd16, "R4 wptr wrapped");
    send(8'h24, 28'h4, 8'h4, 8'h4, 16'h4); wait_idle();
    rd(3'd4, 32'd33, "R5 overflow flag set");
    send(8'h25, 28'h5, 8'h5, 8'h5, 16'h5); wait_idle();
    rd(3'd4, 32'd49, "R5 overflow flag sticky");
    cfg_wr(3'd0, 32'h2F);
    rd(3'd4, 32'd48, "R5 overflow flag cleared");

    // R7: interrupts off while pending
    cfg_wr(3'd0, 32'h0D);
    @(negedge clk); chk("R7 irq off when disabled", irq_out, 0);

    // R8: disabled ring refuses events and takes pointer writes
    cfg_wr(3'd0, 32'h00);
    @(posedge clk); #1 ev_valid = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 ev_ready low while disabled", ev_ready, 0);
    @(posedge clk); #1 ev_valid = 1'b0;
    cfg_wr(3'd4, 32'h0);
    cfg_wr(3'd3, 32'h0);
    rd(3'd4, 32'h0, "R8 wptr reset while disabled");
    rd(3'd3, 32'h0, "R8 rptr reset while disabled");
    cfg_wr(3'd0, 32'h0F);
    cfg_wr(3'd4, 32'h20);
    rd(3'd4, 32'h0, "R8 wptr write ignored while enabled");

    // R4 R5: size clamps to the minimum of one vector
    cfg_wr(3'd2, 32'd0);
    send(8'h31, 28'h31, 8'h31, 8'h31, 16'h31); wait_idle();
    rd(3'd4, 32'd1, "R4 clamped size wraps to zero with overflow");
    cfg_wr(3'd2, 32'd31);
    send(8'h32, 28'h32, 8'h32, 8'h32, 16'h32); wait_idle();
    rd(3'd4, 32'd17, "R4 clamped large size");

    // R8: disable mid-vector, vector still completes
    bp_level = 2;
    send(8'h41, 28'h41, 8'h41, 8'h41, 16'h41);
    cfg_wr(3'd0, 32'h08);
    wait_idle();
    bp_level = 0;
    rd(3'd4, 32'd33, "R8 in-flight vector completed");

    repeat (4) @(negedge clk);
    chk("R3 all expected writes seen", 64'(q_kind.size()), 0);
    finish_run();
  end

endmodule